// File: doc/BRIEF.md
# Double-Buffered Serial Word Receiver for a DAC Code

This block is the digital front end of a 12-bit voltage-output converter. A host drives five slow pins: a serial data line, a serial clock, an active-low select, an active-low load strobe and an active-low clear. The block runs on a fast system clock and oversamples those pins. Every pin passes through a two-flop synchronizer. A rising edge of the serial clock is found by comparing the latest synchronized sample with the one before it. The system clock must run at least four times faster than the serial clock.

Two registers hold the data. The shift register collects an incoming word while the converter code on the output stays as it is. The code register feeds the converter. The load strobe is level sensitive: while it is low, the code register follows the shift register, and when it goes high again the code register keeps the last value. The select pin gates only the shifting, never the load. The clear pin drives the code to zero and overrides the load. The block also reports two things: a status that says a full word has arrived, and a sticky flag that records a serial clock edge seen while the load strobe was low.

Top module: `sdac_frontend`

## Requirements
- R1: While `rst` is high and after it is released, `dac_code` is 0, `word_done` is 0 and `proto_err` is 0.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into bit 0 of the shift register, and the earlier bits move one place toward bit 11. The first of twelve bits therefore ends up in bit 11 (most significant first). A later load puts that word on `dac_code`.
- R3: While `cs_n` is high, edges on `sclk` leave the shift register unchanged. A load after such edges shows the word held before them.
- R4: While the shift register is filling and `ld_n` stays high, `dac_code` keeps its previous value.
- R5: A low pulse on `ld_n` moves the word into the code register whether `cs_n` is high or low.
- R6: While `ld_n` is low, `dac_code` follows the shift register. Once `ld_n` is high again, `dac_code` holds the last value it took and ignores further shifting.
- R7: While `clr_n` is low (held for at least 3 system clocks), `dac_code` is 0 even if `ld_n` is low. After `clr_n` is released, `dac_code` stays 0 until the next load.
- R8: `proto_err` becomes 1 when an `sclk` rising edge is seen while both `cs_n` and `ld_n` are low. It then stays 1 until `rst`. That edge still shifts its bit in.
- R9: `word_done` is 1 only when exactly 12 `sclk` rising edges have been taken since `cs_n` went low. It falls on a 13th edge. When `cs_n` goes high the count returns to zero and `word_done` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data pin |
| sclk | input | 1 | Serial clock pin; data is taken on its rising edge |
| cs_n | input | 1 | Active-low select; enables shifting |
| ld_n | input | 1 | Active-low level-sensitive load strobe |
| clr_n | input | 1 | Active-low clear of the code register |
| dac_code | output | 12 | Code driven to the converter |
| word_done | output | 1 | A full word has been shifted since select fell |
| proto_err | output | 1 | Sticky flag: clock edge seen while load was low |

## Verification
On every cycle, the assertions check that the shift register moves only on a detected clock edge while the select is low, that the code register holds its value when load and clear are both inactive, that it copies the shift register when load is active, and that a clear leaves zero. They also check that the error flag is sticky and is set only by its own cause. Some behaviours need whole scenarios driven at the pins, and only the bench can show them: the bit order of complete words, a preloaded word leaving the present code untouched, zero persisting after clear until a new load, and the word count rising and falling around the twelfth edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int DEF_WORD_W = 12;

    typedef struct packed {
        logic sdi;
        logic sclk;
        logic cs_n;
        logic ld_n;
        logic clr_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sdi: 1'b0, sclk: 1'b0, cs_n: 1'b1, ld_n: 1'b1, clr_n: 1'b1};

    function automatic logic rising(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
    parameter int           W      = 5,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{IDLE[b]}};
            else     chain <= {chain[STAGES-2:0], raw_i[b]};
        end
        assign sync_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sdac_edge_detect.sv
module sdac_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev;
    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level_i;
    end
    assign rise_o = sdac_pkg::rising(level_i, prev);
endmodule

// File: rtl/sdac_shift_unit.sv
module sdac_shift_unit #(
    parameter int WORD_W = sdac_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi_i,
    input  logic              edge_i,
    input  logic              cs_n_i,
    input  logic              ld_n_i,
    output logic [WORD_W-1:0] shreg_o,
    output logic              word_done_o,
    output logic              proto_err_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

    logic [CNT_W-1:0] bit_cnt;
    logic             take;

    assign take = edge_i & ~cs_n_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_o     <= '0;
            bit_cnt     <= '0;
            proto_err_o <= 1'b0;
        end else begin
            if (take) shreg_o <= {shreg_o[WORD_W-2:0], sdi_i};
            if (cs_n_i)    bit_cnt <= '0;
            else if (take && bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
            if (take && !ld_n_i) proto_err_o <= 1'b1;
        end
    end

    assign word_done_o = (bit_cnt == CNT_FULL);

    p_deselect_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |=> $stable(shreg_o));
    p_shift_on_edge_only_r2: assert property (@(posedge clk) disable iff (rst)
        !edge_i |=> $stable(shreg_o));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> proto_err_o);
    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_err_o) |-> $past(edge_i && !cs_n_i && !ld_n_i));
    p_count_restart_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |=> !word_done_o);
endmodule

// File: rtl/sdac_dac_hold.sv
module sdac_dac_hold #(
    parameter int WORD_W = sdac_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n_i,
    input  logic              clr_n_i,
    input  logic [WORD_W-1:0] shreg_i,
    output logic [WORD_W-1:0] code_o
);
    always_ff @(posedge clk) begin
        if (rst || !clr_n_i) code_o <= '0;
        else if (!ld_n_i)    code_o <= shreg_i;
    end

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_n_i |=> (code_o == '0));
    p_latched_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_n_i && ld_n_i) |=> $stable(code_o));
    p_transparent_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_n_i && !ld_n_i) |=> (code_o == $past(shreg_i)));
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
    parameter int WORD_W = sdac_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              ld_n,
    input  logic              clr_n,
    output logic [WORD_W-1:0] dac_code,
    output logic              word_done,
    output logic              proto_err
);
    import sdac_pkg::*;

    localparam int PIN_W = $bits(pins_t);

    pins_t             raw_pins;
    pins_t             s_pins;
    logic [PIN_W-1:0]  sync_bus;
    logic              sclk_rise;
    logic [WORD_W-1:0] shreg;

    assign raw_pins.sdi   = sdi;
    assign raw_pins.sclk  = sclk;
    assign raw_pins.cs_n  = cs_n;
    assign raw_pins.ld_n  = ld_n;
    assign raw_pins.clr_n = clr_n;

    sdac_pin_sync #(.W(PIN_W), .STAGES(2), .IDLE(PINS_IDLE)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_pins),
        .sync_o (sync_bus)
    );
    assign s_pins = pins_t'(sync_bus);

    sdac_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (s_pins.sclk),
        .rise_o  (sclk_rise)
    );

    sdac_shift_unit #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .sdi_i       (s_pins.sdi),
        .edge_i      (sclk_rise),
        .cs_n_i      (s_pins.cs_n),
        .ld_n_i      (s_pins.ld_n),
        .shreg_o     (shreg),
        .word_done_o (word_done),
        .proto_err_o (proto_err)
    );

    sdac_dac_hold #(.WORD_W(WORD_W)) u_dac (
        .clk     (clk),
        .rst     (rst),
        .ld_n_i  (s_pins.ld_n),
        .clr_n_i (s_pins.clr_n),
        .shreg_i (shreg),
        .code_o  (dac_code)
    );
endmodule

// File: tb/sdac_frontend_tb_top.sv
`timescale 1ns/100ps
module sdac_frontend_tb_top;
    localparam int W    = 12;
    localparam int HALF = 4;
    localparam int NVEC = 6;
    localparam logic [W-1:0] VEC [NVEC] = '{12'hA5C, 12'h000, 12'hFFF, 12'h801, 12'h7FE, 12'h3C3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdi = 1'b0, sclk = 1'b0, cs_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [W-1:0] dac_code;
    logic word_done, proto_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdac_frontend #(.WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .sdi(sdi), .sclk(sclk), .cs_n(cs_n),
        .ld_n(ld_n), .clr_n(clr_n), .dac_code(dac_code),
        .word_done(word_done), .proto_err(proto_err)
    );

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdi = b;  waitn(HALF);
        sclk = 1; waitn(HALF);
        sclk = 0; waitn(HALF);
    endtask

    task automatic send_bits(input logic [W-1:0] w, input int n);
        for (int i = W - 1; i >= W - n; i--) send_bit(w[i]);
    endtask

    task automatic pulse_ld();
        ld_n = 0; waitn(HALF);
        ld_n = 1; waitn(HALF);
    endtask

    initial begin
        logic [W-1:0] prev;
        waitn(5);
        check("R1 code in reset", dac_code, 0);
        rst = 0; waitn(3);
        check("R1 code", dac_code, 0);
        check("R1 word_done", word_done, 0);
        check("R1 proto_err", proto_err, 0);

        // R2 R4 R5 R9: table of words, each loaded after select rises
        prev = '0;
        for (int v = 0; v < NVEC; v++) begin
            cs_n = 0; waitn(HALF);
            send_bits(VEC[v], W);
            check("R9 word_done after 12 edges", word_done, 1);
            check("R4 code kept during preload", dac_code, prev);
            cs_n = 1; waitn(HALF);
            pulse_ld();
            check("R2/R5 loaded word", dac_code, VEC[v]);
            prev = VEC[v];
        end

        // R3: clocking while deselected is ignored
        cs_n = 1;
        send_bits(12'h5A5, W);
        pulse_ld();
        check("R3 shift ignored when deselected", dac_code, VEC[NVEC-1]);

        // R9: count boundaries
        cs_n = 0; waitn(HALF);
        send_bits(12'h123, 11);
        check("R9 word_done after 11 edges", word_done, 0);
        send_bit(1'b1);
        check("R9 word_done after 12 edges", word_done, 1);
        send_bit(1'b0);
        check("R9 word_done after 13 edges", word_done, 0);
        cs_n = 1; waitn(HALF);
        check("R9 word_done cleared by deselect", word_done, 0);
        cs_n = 0; waitn(HALF);
        send_bits(12'hC3A, W);
        check("R9 recount after deselect", word_done, 1);
        check("R8 no error yet", proto_err, 0);

        // R6 R8: transparent load, shifting while load low
        ld_n = 0; waitn(HALF);
        check("R6 transparent follows", dac_code, 12'hC3A);
        send_bit(1'b1);
        check("R6 follows shift while low", dac_code, 12'h875);
        check("R8 error set", proto_err, 1);
        ld_n = 1; waitn(HALF);
        send_bits(12'hFFF, 4);
        check("R6 latched after release", dac_code, 12'h875);
        check("R8 error sticky", proto_err, 1);
        cs_n = 1; waitn(HALF);

        // R7: clear priority and persistence
        clr_n = 0; waitn(HALF);
        check("R7 clear zero", dac_code, 0);
        ld_n = 0; waitn(HALF);
        check("R7 clear over load", dac_code, 0);
        ld_n = 1; waitn(HALF);
        clr_n = 1; waitn(HALF);
        check("R7 zero kept after release", dac_code, 0);
        pulse_ld();
        check("R7 next load restores", dac_code, 12'h75F);

        // R1/R8: reset clears flag and registers
        rst = 1; waitn(2);
        rst = 0; waitn(2);
        check("R8 error cleared by reset", proto_err, 0);
        check("R1 code after reset", dac_code, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (R1..): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule